// File: doc/BRIEF.md
# Seven-to-one video link deserializer

The block turns five serial video lanes into one 35-bit parallel word per pixel period. Each lane sends seven bits per pixel, and a framing clock marks the word boundaries. The block runs on a bit-rate clock at seven times the pixel rate, which is supplied from outside. On each rising edge of the framing clock it restarts its bit count. After the seventh bit it moves all five lane words into one holding register at the same moment.

It also makes a pixel-rate output clock. An edge-select input sets which edge of that clock falls in the middle of a stable data word. A power-down input forces the data and the clock to zero. An output-enable input disables both buses so that they go to high impedance. The outputs are tri-state ports, and each bus has its own enable output next to it.

Top module: `deser7_rx`

## Requirements
- R1: Lane L fills data_o[7L+6:7L]. Bits arrive most significant first, and the bit sampled in the same bit clock as the framing clock's rising edge becomes bit 6.
- R2: Any rising edge of the framing clock restarts word alignment. A word that had fewer than seven bits when the edge came is discarded and never reaches the outputs.
- R3: All 35 data bits change together, one bit clock after the seventh bit is sampled. They then hold until the next complete word.
- R4: After each word update, an internal pixel clock is low for four bit clocks and high until the next update. With edge_sel_i=1, clk_o equals that clock, so the rising edge falls mid-word. With edge_sel_i=0, clk_o is its inverse.
- R5: With oe_i=1 and pd_ni=0, data_o is all zero and clk_o is 0.
- R6: After pd_ni returns high, data_o and clk_o stay 0 until a complete word is captured. Every one of that word's seven bits, from its framing edge onward, must be sampled with pd_ni high. A word whose last bit is sampled while pd_ni is low is dropped.
- R7: With oe_i=0, data_oe_o and clk_oe_o are 0 and both output buses are high impedance, whatever pd_ni and edge_sel_i are. With oe_i=1, both enables are 1.
- R8: test_i has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bit-rate clock, seven times the pixel rate |
| rst_ni | input | 1 | Active-low asynchronous reset |
| lane_i | input | 5 | Serial data lanes, one bit per bit clock |
| frame_i | input | 1 | Pixel-rate framing clock; its rising edge marks bit 6 |
| edge_sel_i | input | 1 | 1: rising clk_o edge mid-word; 0: falling edge mid-word |
| pd_ni | input | 1 | 0 = power down |
| oe_i | input | 1 | 1 = outputs driven; 0 = high impedance |
| test_i | input | 1 | Reserved; tie low; no effect |
| data_o | output | 35 | Parallel word, tri-state |
| clk_o | output | 1 | Pixel-rate output clock, tri-state |
| data_oe_o | output | 1 | Drive enable of data_o |
| clk_oe_o | output | 1 | Drive enable of clk_o |

## Verification
Power-down can fall in the same bit clock in which the seventh bit of a word is sampled. The bench provokes this by lowering pd_ni together with that last bit. It then expects zero data at once, and zero data after release until a fresh, fully powered word has arrived. A second overlap is a framing edge that lands part-way through a word. It is provoked by a truncated burst, and the bench judges it by requiring that only the following full word appears. Edge select, output enable and the test input are randomized word by word against a bench model of the hold register and the clock phase.

// File: rtl/deser7_pkg.sv
`timescale 1ns/1ps
package deser7_pkg;
  localparam int unsigned DEF_LANES = 5;
  localparam int unsigned DEF_BITS  = 7;
endpackage

// File: rtl/deser7_lane.sv
`timescale 1ns/1ps
module deser7_lane #(
  parameter int unsigned BITS = 7
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            bit_i,
  output logic [BITS-2:0] shift_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) shift_o <= '0;
    else         shift_o <= {shift_o[BITS-3:0], bit_i};
  end
endmodule

// File: rtl/deser7_align.sv
`timescale 1ns/1ps
module deser7_align #(
  parameter int unsigned BITS = 7
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic frame_i,
  output logic capture_o
);
  localparam int unsigned CW = $clog2(BITS + 1);
  localparam logic [CW-1:0] LAST = CW'(BITS - 1);

  logic          frame_q;
  logic [CW-1:0] cnt_q;
  logic          rise;

  assign rise      = frame_i & ~frame_q;
  assign capture_o = en_i & ~rise & (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      frame_q <= 1'b0;
      cnt_q   <= '0;
    end else begin
      frame_q <= frame_i;
      if (!en_i)              cnt_q <= '0;
      else if (rise)          cnt_q <= CW'(1);
      else if (cnt_q == LAST) cnt_q <= '0;
      else if (cnt_q != '0)   cnt_q <= cnt_q + CW'(1);
    end
  end

  // word boundaries are at least two bit clocks apart
  p_capture_gap_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    capture_o |=> !capture_o);
endmodule

// File: rtl/deser7_hold.sv
`timescale 1ns/1ps
module deser7_hold #(
  parameter int unsigned W = 35
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         pd_ni,
  input  logic         capture_i,
  input  logic [W-1:0] word_i,
  output logic [W-1:0] word_o,
  output logic         valid_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      word_o  <= '0;
      valid_o <= 1'b0;
    end else begin
      if (capture_i) word_o <= word_i;
      if (!pd_ni)         valid_o <= 1'b0;
      else if (capture_i) valid_o <= 1'b1;
    end
  end

  p_hold_stable_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !capture_i |=> $stable(word_o));
  p_pd_clears_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pd_ni |=> !valid_o);
endmodule

// File: rtl/deser7_out.sv
`timescale 1ns/1ps
module deser7_out #(
  parameter int unsigned W    = 35,
  parameter int unsigned BITS = 7
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         capture_i,
  input  logic         valid_i,
  input  logic         pd_ni,
  input  logic         oe_i,
  input  logic         edge_sel_i,
  input  logic [W-1:0] word_i,
  output logic [W-1:0] data_o,
  output logic         clk_o,
  output logic         data_oe_o,
  output logic         clk_oe_o
);
  localparam int unsigned PW = $clog2(BITS);
  localparam logic [PW-1:0] PH_MAX  = PW'(BITS - 1);
  localparam logic [PW-1:0] PH_HIGH = PW'((BITS - 1) / 2);

  logic [PW-1:0] ph_q;
  logic          raw_q;
  logic          run;
  logic [W-1:0]  data_val;
  logic          clk_val;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q  <= PH_MAX;
      raw_q <= 1'b0;
    end else if (!pd_ni) begin
      ph_q  <= PH_MAX;
      raw_q <= 1'b0;
    end else if (capture_i) begin
      ph_q  <= '0;
      raw_q <= 1'b0;
    end else begin
      if (ph_q != PH_MAX)  ph_q  <= ph_q + PW'(1);
      if (ph_q == PH_HIGH) raw_q <= 1'b1;
    end
  end

  assign run       = pd_ni & valid_i;
  assign data_val  = run ? word_i : '0;
  assign clk_val   = run & (edge_sel_i ? raw_q : ~raw_q);
  assign data_oe_o = oe_i;
  assign clk_oe_o  = oe_i;
  assign data_o    = data_oe_o ? data_val : 'z;
  assign clk_o     = clk_oe_o ? clk_val : 1'bz;

  p_clk_phase_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (capture_i && pd_ni) |=> (!raw_q && ph_q == '0));
  p_clk_fixed_pd_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pd_ni |=> !raw_q);
endmodule

// File: rtl/deser7_rx.sv
`timescale 1ns/1ps
module deser7_rx
  import deser7_pkg::*;
#(
  parameter int unsigned LANES = DEF_LANES,
  parameter int unsigned BITS  = DEF_BITS
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [LANES-1:0]      lane_i,
  input  logic                  frame_i,
  input  logic                  edge_sel_i,
  input  logic                  pd_ni,
  input  logic                  oe_i,
  input  logic                  test_i,
  output logic [LANES*BITS-1:0] data_o,
  output logic                  clk_o,
  output logic                  data_oe_o,
  output logic                  clk_oe_o
);
  localparam int unsigned W = LANES * BITS;

  logic [LANES-1:0][BITS-2:0] shift;
  logic [W-1:0]               word_in;
  logic [W-1:0]               word_q;
  logic                       capture;
  logic                       valid;
  logic                       unused_test;

  assign unused_test = test_i;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    deser7_lane #(.BITS(BITS)) u_lane (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .bit_i  (lane_i[l]),
      .shift_o(shift[l])
    );
    assign word_in[l*BITS +: BITS] = {shift[l], lane_i[l]};
  end

  deser7_align #(.BITS(BITS)) u_align (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (pd_ni),
    .frame_i  (frame_i),
    .capture_o(capture)
  );

  deser7_hold #(.W(W)) u_hold (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .pd_ni    (pd_ni),
    .capture_i(capture),
    .word_i   (word_in),
    .word_o   (word_q),
    .valid_o  (valid)
  );

  deser7_out #(.W(W), .BITS(BITS)) u_out (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .capture_i (capture),
    .valid_i   (valid),
    .pd_ni     (pd_ni),
    .oe_i      (oe_i),
    .edge_sel_i(edge_sel_i),
    .word_i    (word_q),
    .data_o    (data_o),
    .clk_o     (clk_o),
    .data_oe_o (data_oe_o),
    .clk_oe_o  (clk_oe_o)
  );
endmodule

// File: tb/deser7_rx_bench.sv
`timescale 1ns/1ps
module deser7_rx_bench;
  localparam int LANES = 5;
  localparam int BITS  = 7;
  localparam int W     = LANES * BITS;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [LANES-1:0] lane = '0;
  logic             frame = 1'b0;
  logic             edge_sel = 1'b1;
  logic             pd_n = 1'b1;
  logic             oe = 1'b1;
  logic             test = 1'b0;
  wire  [W-1:0]     data;
  wire              clk_out;
  wire              data_oe;
  wire              clk_oe;

  int n_chk = 0;
  int n_fail = 0;
  logic [W-1:0] exp_word = '0;
  logic         exp_valid = 1'b0;
  int unsigned  seed_dummy;

  always #4 clk = ~clk;

  deser7_rx u_deser7_rx (
    .clk_i(clk), .rst_ni(rst_n), .lane_i(lane), .frame_i(frame),
    .edge_sel_i(edge_sel), .pd_ni(pd_n), .oe_i(oe), .test_i(test),
    .data_o(data), .clk_o(clk_out), .data_oe_o(data_oe), .clk_oe_o(clk_oe)
  );

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [W-1:0] exp_data();
    return (pd_n && exp_valid) ? exp_word : '0;
  endfunction

  // raw_high: internal pixel clock phase expected at this moment
  function automatic logic exp_clk(logic raw_high);
    if (!(pd_n && exp_valid)) return 1'b0;
    return edge_sel ? raw_high : ~raw_high;
  endfunction

  task automatic check_outputs(string tag, logic raw_high);
    check({tag, " R7 enables"}, {62'd0, data_oe, clk_oe}, {62'd0, oe, oe});
    if (oe) begin
      check({tag, " R1 R3 R5 R6 data"}, 64'(data), 64'(exp_data()));
      check({tag, " R4 R5 R6 clk"}, 64'(clk_out), 64'(exp_clk(raw_high)));
    end
  endtask

  // one full word; pd_pat[k] is pd_ni for bit k; a gap bit follows
  task automatic send(logic [W-1:0] w, logic [6:0] pd_pat, logic midchk);
    logic ok;
    ok = 1'b1;
    if (!pd_n) exp_valid = 1'b0;  // gap bit sampled with pd low
    for (int k = 0; k < BITS; k++) begin
      @(negedge clk);
      if (k == 4 && midchk) check_outputs("mid R3 R4", 1'b1);
      pd_n  = pd_pat[k];
      frame = (k < 4);
      for (int l = 0; l < LANES; l++) lane[l] = w[l*BITS + 6 - k];
      if (!pd_pat[k]) begin
        ok = 1'b0;
        exp_valid = 1'b0;
      end
    end
    @(negedge clk);
    if (ok) begin
      exp_word  = w;
      exp_valid = 1'b1;
    end
    check_outputs("post", 1'b0);
  endtask

  task automatic partial(int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      frame = (k < n - 1);
      lane  = LANES'($urandom);
    end
    if (!pd_n) exp_valid = 1'b0;
  endtask

  function automatic logic [W-1:0] rnd_word();
    return W'({$urandom, $urandom});
  endfunction

  initial begin
    #(8 * 200000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail + 1, n_chk + 1);
    $finish;
  end

  initial begin
    seed_dummy = $urandom(32'h5eed_0017);
    repeat (3) @(negedge clk);
    // reset state: R5 R6 R7
    check("reset R7 enables", {62'd0, data_oe, clk_oe}, 64'd3);
    check("reset R6 data", 64'(data), 64'd0);
    check("reset R6 clk", 64'(clk_out), 64'd0);
    rst_n = 1'b1;

    // directed R1 bit order
    send(35'h4_0000_0001, 7'h7f, 1'b0);
    send(35'h1_2345_6789, 7'h7f, 1'b1);
    edge_sel = 1'b0;
    send(35'h7_ffff_fffe, 7'h7f, 1'b1);
    edge_sel = 1'b1;

    // R2: truncated word, then full word
    partial(3);
    send(35'h2_aaaa_5555, 7'h7f, 1'b0);
    partial(6);
    send(35'h5_5555_aaaa, 7'h7f, 1'b0);

    // R5: power down across a whole word
    send(rnd_word(), 7'h00, 1'b1);
    // R6: release part-way through a word, word dropped
    send(rnd_word(), 7'b1111000, 1'b1);
    send(35'h3_1415_9265, 7'h7f, 1'b1);
    // R6: pd falls with the last bit of a word
    send(rnd_word(), 7'b0111111, 1'b0);
    send(rnd_word(), 7'h7f, 1'b1);

    // R7: output disable with pd in both states
    oe = 1'b0;
    send(rnd_word(), 7'h00, 1'b1);
    send(rnd_word(), 7'h7f, 1'b1);
    oe = 1'b1;
    send(rnd_word(), 7'h7f, 1'b1);

    // random traffic, R8 test toggling
    for (int i = 0; i < 200; i++) begin
      logic [6:0] pp;
      edge_sel = 1'($urandom);
      oe       = ($urandom % 8) != 0;
      test     = 1'($urandom);
      pp       = (($urandom % 10) == 0) ? 7'($urandom) : 7'h7f;
      if (($urandom % 12) == 0) partial(1 + int'($urandom % 6));
      send(rnd_word(), pp, 1'b1);
    end
    test = 1'b1;
    oe = 1'b1;
    send(35'h0_dead_beef, 7'h7f, 1'b1);
    send(35'h0_0000_0000, 7'h7f, 1'b1);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule